// File: doc/BRIEF.md
# Integration Cycle Sequencer with Correlated Double Sampling

This block times one continuous integration cycle of an integrating converter front end and reduces the digital sample stream taken during that cycle to a single signed result. A cycle is started by a one-clock strobe. It passes through an acquisition phase, an optional initial sample group, a tracking interval of programmable length, and a final sample group. The acquisition length, the group size and the tracking length are all set by the configuration inputs.

Each sample group is summed and then divided by its size with an arithmetic shift, which gives the group average. With correlated double sampling enabled, the result is the final average minus the initial average. With it disabled, the initial group is skipped and the result is the final average alone. The result is loaded into a serial register and `valid_o` rises. A reader then clocks the result out MSB first with `shift_i`. The result stays in place until the next cycle finishes, and that cycle overwrites it whether or not it was read.

Top module: `intcyc_seq`

## Requirements
- R1: `phase_o` reports 0 idle, 1 acquisition, 2 initial group, 3 tracking, 4 final group, 5 result latch. During a cycle the code never decreases, and the block returns to 0 after the single latch cycle.
- R2: The acquisition phase lasts 1 clock for `acq_sel_i`=0, 16 clocks for 1, and 32 clocks for 2 or 3.
- R3: Each sample group lasts M = 2^`m_log_i` clocks and takes one sample per clock. A `m_log_i` above 8 is treated as 8, so M = 256.
- R4: With `cds_en_i`=1 the initial group runs for M clocks and the result is the final average minus the initial average. With `cds_en_i`=0 phase 2 never occurs and the result is the final average.
- R5: The tracking interval lasts `track_len_i`+1 clocks.
- R6: A group average is the group sum shifted right arithmetically by log2(M). The result is a two's complement value of SAMPLE_W+1 = 17 bits, which covers the full span from -65535 to +65535.
- R7: Exactly K + (CDS ? M : 0) + (`track_len_i`+1) + M + 1 rising edges after the edge that accepts the start, `phase_o` is 0 and `valid_o` is 1.
- R8: A result stays readable until the next cycle latches its own result. That cycle overwrites the old result even if the old one was only partly read.
- R9: `start_i` is accepted only while `phase_o` is 0. The configuration inputs are sampled only on an accepted start, so changes to them during a cycle have no effect.
- R10: After a load, `ser_o` shows the result MSB. Each `shift_i` pulse while `valid_o` is 1 moves to the next bit. `valid_o` clears on the 17th shift.
- R11: After reset, `phase_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Cycle start strobe |
| cds_en_i | input | 1 | Correlated double sampling enable |
| acq_sel_i | input | 2 | Acquisition length select |
| m_log_i | input | 4 | log2 of the group sample count |
| track_len_i | input | 16 | Tracking interval length minus one |
| sample_i | input | 16 | Signed sample stream, one sample per clock |
| shift_i | input | 1 | Serial read strobe |
| ser_o | output | 1 | Serial result bit, MSB first |
| valid_o | output | 1 | Result available for reading |
| phase_o | output | 3 | Current phase code |

## Verification
The bench counts rising edges from the edge that accepts the start. At count K + (CDS ? M : 0) + track+1 + M + 1 it expects `valid_o` high and `phase_o` idle, and it records `phase_o` once per cycle so that it can compare the clocks spent in each phase with K, M and track+1. It computes the sample applied in cycle n itself and places that sample in the initial or final group by cycle index alone. All outputs are read 1 ns after an edge. `ser_o` is captured before each shift pulse, and the next bit is expected after the following edge.

// File: rtl/intcyc_pkg.sv
package intcyc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ACQ   = 3'd1,
    PH_INIT  = 3'd2,
    PH_TRACK = 3'd3,
    PH_FINAL = 3'd4,
    PH_LATCH = 3'd5
  } phase_t;

  // Acquisition clock count for a select code.
  function automatic logic [5:0] acq_clocks(input logic [1:0] sel);
    case (sel)
      2'd0:    acq_clocks = 6'd1;
      2'd1:    acq_clocks = 6'd16;
      default: acq_clocks = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/intcyc_phase_ctl.sv
module intcyc_phase_ctl
  import intcyc_pkg::*;
#(
  parameter int TRACK_W   = 16,
  parameter int MAX_LOG_M = 8,
  parameter int LOGM_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               cds_en_i,
  input  logic [1:0]         acq_sel_i,
  input  logic [LOGM_W-1:0]  m_log_i,
  input  logic [TRACK_W-1:0] track_len_i,
  output phase_t             phase_o,
  output logic               cfg_cds_o,
  output logic [LOGM_W-1:0]  cfg_mlog_o,
  output logic               clear_o,
  output logic               latch_o,
  output logic [1:0]         grp_en_o
);

  localparam int GRP_W  = MAX_LOG_M + 1;
  localparam int BASE_W = (TRACK_W > GRP_W) ? TRACK_W : GRP_W;
  localparam int CNT_W  = (BASE_W > 6) ? BASE_W : 6;

  phase_t             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               cds_q;
  logic [LOGM_W-1:0]  mlog_q;
  logic [TRACK_W-1:0] track_q;

  logic               accept;
  logic               cnt_zero;
  logic [CNT_W-1:0]   grp_last;
  logic [CNT_W-1:0]   track_last;
  logic [LOGM_W-1:0]  mlog_clamped;

  assign accept       = start_i && (phase_q == PH_IDLE);
  assign cnt_zero     = (cnt_q == '0);
  assign grp_last     = (CNT_W'(1) << mlog_q) - CNT_W'(1);
  assign track_last   = CNT_W'(track_q);
  assign mlog_clamped = (m_log_i > LOGM_W'(MAX_LOG_M)) ? LOGM_W'(MAX_LOG_M) : m_log_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cds_q   <= 1'b0;
      mlog_q  <= '0;
      track_q <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            cds_q   <= cds_en_i;
            mlog_q  <= mlog_clamped;
            track_q <= track_len_i;
            cnt_q   <= CNT_W'(acq_clocks(acq_sel_i) - 6'd1);
            phase_q <= PH_ACQ;
          end
        end
        PH_ACQ: begin
          if (cnt_zero) begin
            if (cds_q) begin
              phase_q <= PH_INIT;
              cnt_q   <= grp_last;
            end else begin
              phase_q <= PH_TRACK;
              cnt_q   <= track_last;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_INIT: begin
          if (cnt_zero) begin
            phase_q <= PH_TRACK;
            cnt_q   <= track_last;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_TRACK: begin
          if (cnt_zero) begin
            phase_q <= PH_FINAL;
            cnt_q   <= grp_last;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        PH_FINAL: begin
          if (cnt_zero) begin
            phase_q <= PH_LATCH;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: begin
          phase_q <= PH_IDLE;
        end
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign cfg_cds_o   = cds_q;
  assign cfg_mlog_o  = mlog_q;
  assign clear_o     = accept;
  assign latch_o     = (phase_q == PH_LATCH);
  assign grp_en_o[0] = (phase_q == PH_INIT);
  assign grp_en_o[1] = (phase_q == PH_FINAL);

endmodule

// File: rtl/intcyc_group_acc.sv
module intcyc_group_acc #(
  parameter int SAMPLE_W  = 16,
  parameter int MAX_LOG_M = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 clr_i,
  input  logic                                 en_i,
  input  logic signed [SAMPLE_W-1:0]           sample_i,
  output logic signed [SAMPLE_W+MAX_LOG_M-1:0] sum_o
);

  localparam int SUM_W = SAMPLE_W + MAX_LOG_M;

  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] sample_ext;

  assign sample_ext = {{MAX_LOG_M{sample_i[SAMPLE_W-1]}}, sample_i};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sum_q <= '0;
    end else if (en_i) begin
      sum_q <= sum_q + sample_ext;
    end
  end

  assign sum_o = sum_q;

endmodule

// File: rtl/intcyc_ser_out.sv
module intcyc_ser_out #(
  parameter int RES_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             shift_i,
  output logic             ser_o,
  output logic             valid_o,
  output logic             last_bit_o
);

  localparam int BIT_W = $clog2(RES_W + 1);

  logic [RES_W-1:0] shreg_q;
  logic [BIT_W-1:0] sent_q;
  logic             valid_q;

  assign last_bit_o = (sent_q == BIT_W'(RES_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      sent_q  <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      shreg_q <= data_i;
      sent_q  <= '0;
      valid_q <= 1'b1;
    end else if (shift_i && valid_q) begin
      shreg_q <= {shreg_q[RES_W-2:0], 1'b0};
      sent_q  <= sent_q + BIT_W'(1);
      if (last_bit_o) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign ser_o   = shreg_q[RES_W-1];
  assign valid_o = valid_q;

endmodule

// File: rtl/intcyc_seq.sv
module intcyc_seq
  import intcyc_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int TRACK_W   = 16,
  parameter int MAX_LOG_M = 8,
  parameter int LOGM_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                cds_en_i,
  input  logic [1:0]          acq_sel_i,
  input  logic [LOGM_W-1:0]   m_log_i,
  input  logic [TRACK_W-1:0]  track_len_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                shift_i,
  output logic                ser_o,
  output logic                valid_o,
  output logic [2:0]          phase_o
);

  localparam int SUM_W  = SAMPLE_W + MAX_LOG_M;
  localparam int RES_W  = SAMPLE_W + 1;
  localparam int N_GRP  = 2;

  phase_t            phase_w;
  logic              cfg_cds_w;
  logic [LOGM_W-1:0] cfg_mlog_w;
  logic              clear_w;
  logic              latch_w;
  logic [1:0]        grp_en_w;
  logic              last_bit_w;

  logic signed [SUM_W-1:0] grp_sum [N_GRP];
  logic signed [SUM_W-1:0] grp_avg [N_GRP];
  logic signed [RES_W-1:0] avg_init;
  logic signed [RES_W-1:0] avg_final;
  logic signed [RES_W-1:0] result_w;

  intcyc_phase_ctl #(
    .TRACK_W   (TRACK_W),
    .MAX_LOG_M (MAX_LOG_M),
    .LOGM_W    (LOGM_W)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cds_en_i    (cds_en_i),
    .acq_sel_i   (acq_sel_i),
    .m_log_i     (m_log_i),
    .track_len_i (track_len_i),
    .phase_o     (phase_w),
    .cfg_cds_o   (cfg_cds_w),
    .cfg_mlog_o  (cfg_mlog_w),
    .clear_o     (clear_w),
    .latch_o     (latch_w),
    .grp_en_o    (grp_en_w)
  );

  // Index 0 collects the initial group, index 1 the final group.
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    intcyc_group_acc #(
      .SAMPLE_W  (SAMPLE_W),
      .MAX_LOG_M (MAX_LOG_M)
    ) u_acc (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (clear_w),
      .en_i     (grp_en_w[g]),
      .sample_i (sample_i),
      .sum_o    (grp_sum[g])
    );
    assign grp_avg[g] = grp_sum[g] >>> cfg_mlog_w;
  end

  // Averages fit in SAMPLE_W bits, so taking the low RES_W bits keeps the sign.
  assign avg_init  = RES_W'(grp_avg[0]);
  assign avg_final = RES_W'(grp_avg[1]);
  assign result_w  = cfg_cds_w ? (avg_final - avg_init) : avg_final;

  intcyc_ser_out #(
    .RES_W (RES_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .load_i     (latch_w),
    .data_i     (result_w),
    .shift_i    (shift_i),
    .ser_o      (ser_o),
    .valid_o    (valid_o),
    .last_bit_o (last_bit_w)
  );

  assign phase_o = phase_w;

endmodule

// File: rtl/intcyc_seq_chk.sv
module intcyc_seq_chk
  import intcyc_pkg::*;
#(
  parameter int LOGM_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              shift_i,
  input logic              valid_o,
  input logic [2:0]        phase_o,
  input logic              cfg_cds,
  input logic [LOGM_W-1:0] cfg_mlog,
  input logic              last_bit
);

  // R1: legal successors of every phase.
  a_r1_acq_next: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_ACQ) |=> (phase_o == PH_ACQ || phase_o == PH_INIT || phase_o == PH_TRACK));
  a_r1_init_next: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_INIT) |=> (phase_o == PH_INIT || phase_o == PH_TRACK));
  a_r1_track_next: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_TRACK) |=> (phase_o == PH_TRACK || phase_o == PH_FINAL));
  a_r1_final_next: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_FINAL) |=> (phase_o == PH_FINAL || phase_o == PH_LATCH));
  a_r1_latch_next: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_LATCH) |=> (phase_o == PH_IDLE));

  // R4: the initial group exists only with CDS on.
  a_r4_init_needs_cds: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_INIT) |-> cfg_cds);

  // R7 / R8: a latch always leaves a valid result.
  a_r8_latch_sets_valid: assert property (@(posedge clk) disable iff (rst)
    (phase_o == PH_LATCH) |=> valid_o);
  a_r7_valid_from_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> ($past(phase_o) == PH_LATCH));

  // R9: a start during a cycle leaves the sampled configuration alone.
  a_r9_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    (start_i && phase_o != PH_IDLE) |=> ($stable(cfg_cds) && $stable(cfg_mlog)));

  // R10: the last shift clears valid.
  a_r10_valid_clears: assert property (@(posedge clk) disable iff (rst)
    (valid_o && shift_i && last_bit && phase_o != PH_LATCH) |=> !valid_o);

  // R11: reset state.
  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (phase_o == PH_IDLE && !valid_o));

endmodule

bind intcyc_seq intcyc_seq_chk #(
  .LOGM_W (LOGM_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .shift_i  (shift_i),
  .valid_o  (valid_o),
  .phase_o  (phase_o),
  .cfg_cds  (cfg_cds_w),
  .cfg_mlog (cfg_mlog_w),
  .last_bit (last_bit_w)
);

// File: tb/intcyc_seq_bench.sv
`timescale 1ns/1ps
module intcyc_seq_bench;

  localparam int RES_W = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        cds_en_i = 1'b0;
  logic [1:0]  acq_sel_i = 2'd0;
  logic [3:0]  m_log_i = 4'd0;
  logic [15:0] track_len_i = 16'd0;
  logic [15:0] sample_i = 16'd0;
  logic        shift_i = 1'b0;
  logic        ser_o;
  logic        valid_o;
  logic [2:0]  phase_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  intcyc_seq u_intcyc_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .cds_en_i(cds_en_i),
    .acq_sel_i(acq_sel_i), .m_log_i(m_log_i), .track_len_i(track_len_i),
    .sample_i(sample_i), .shift_i(shift_i), .ser_o(ser_o),
    .valid_o(valid_o), .phase_o(phase_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint samp(input int pat, input int n, input int f0);
    if (pat == 1) return (n < f0) ? 64'sd32767 : -64'sd32768;
    return longint'((n * 7919 + 311) % 60001) - 64'sd30000;
  endfunction

  // Runs one cycle, checks timing and phase order, returns the expected result.
  task automatic run_cycle(input logic cds, input logic [1:0] sel, input int mlog,
                           input int track, input int pat, input logic mid_start,
                           output longint exp_res, output int lat);
    int k, ml, m, f0, exp_lat, prev;
    int ph_cnt [6];
    longint s, sum_i, sum_f, ai, af;
    bit order_ok;
    k  = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 16 : 32;
    ml = (mlog > 8) ? 8 : mlog;
    m  = 1 << ml;
    f0 = k + (cds ? m : 0) + track + 1;
    exp_lat = f0 + m + 1;
    foreach (ph_cnt[i]) ph_cnt[i] = 0;
    sum_i = 0; sum_f = 0; order_ok = 1'b1; lat = -1;
    @(negedge clk);
    cds_en_i = cds; acq_sel_i = sel; m_log_i = 4'(mlog);
    track_len_i = 16'(track); start_i = 1'b1;
    @(posedge clk); #1;
    prev = int'(phase_o);
    ph_cnt[prev]++;
    for (int n = 0; n < exp_lat; n++) begin
      @(negedge clk);
      start_i = mid_start && (n == 2 || n == f0);
      cds_en_i = ~cds; acq_sel_i = ~sel; m_log_i = 4'd1; track_len_i = 16'd7;
      s = samp(pat, n, f0);
      sample_i = 16'(s);
      if (cds && n >= k && n < k + m) sum_i += s;
      if (n >= f0 && n < f0 + m) sum_f += s;
      @(posedge clk); #1;
      if (phase_o == 3'd0 && lat < 0) lat = n + 1;
      if (n + 1 < exp_lat) begin
        if (int'(phase_o) < prev || phase_o > 3'd5) order_ok = 1'b0;
        else ph_cnt[phase_o]++;
        prev = int'(phase_o);
      end
    end
    @(negedge clk); start_i = 1'b0;
    chk("R7 latency to idle", lat, exp_lat);
    chk("R7 valid at finish", valid_o, 1);
    chk("R1 phase order", order_ok, 1);
    chk("R1 latch cycles", ph_cnt[5], 1);
    chk("R2 acquisition clocks", ph_cnt[1], k);
    chk("R4 initial group clocks", ph_cnt[2], cds ? m : 0);
    chk("R5 tracking clocks", ph_cnt[3], track + 1);
    chk("R3 final group clocks", ph_cnt[4], m);
    ai = sum_i >>> ml;
    af = sum_f >>> ml;
    exp_res = cds ? (af - ai) : af;
  endtask

  task automatic read_bits(input int nb, output logic [RES_W-1:0] raw);
    raw = '0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      raw = {raw[RES_W-2:0], ser_o};
      shift_i = 1'b1;
      @(posedge clk); #1;
      shift_i = 1'b0;
    end
  endtask

  task automatic read_result(output longint v);
    logic [RES_W-1:0] raw;
    read_bits(RES_W, raw);
    v = longint'($signed(raw));
  endtask

  task automatic t_reset();
    chk("R11 reset phase", phase_o, 0);
    chk("R11 reset valid", valid_o, 0);
  endtask

  task automatic t_cds_basic();
    longint e, g; int lat;
    run_cycle(1'b1, 2'd1, 3, 5, 0, 1'b0, e, lat);
    repeat (10) @(negedge clk);
    chk("R8 valid held while idle", valid_o, 1);
    read_result(g);
    chk("R6 CDS result", g, e);
    chk("R10 valid clears after last bit", valid_o, 0);
  endtask

  task automatic t_no_cds();
    longint e, g; int lat;
    run_cycle(1'b0, 2'd0, 0, 0, 0, 1'b0, e, lat);
    read_result(g);
    chk("R4 result without CDS", g, e);
  endtask

  task automatic t_long();
    longint e, g; int lat;
    run_cycle(1'b1, 2'd2, 8, 20, 0, 1'b0, e, lat);
    read_result(g);
    chk("R6 M=256 average", g, e);
  endtask

  task automatic t_clamp();
    longint e, g; int lat;
    run_cycle(1'b0, 2'd3, 12, 3, 0, 1'b0, e, lat);
    read_result(g);
    chk("R3 clamped group size result", g, e);
  endtask

  task automatic t_extreme();
    longint e, g; int lat;
    run_cycle(1'b1, 2'd0, 2, 3, 1, 1'b0, e, lat);
    chk("R6 expected extreme value", e, -65535);
    read_result(g);
    chk("R6 extreme CDS result", g, e);
  endtask

  task automatic t_overwrite();
    longint e1, e2, g; int lat;
    logic [RES_W-1:0] raw, e1b;
    run_cycle(1'b1, 2'd1, 2, 4, 0, 1'b0, e1, lat);
    read_bits(5, raw);
    e1b = RES_W'(e1);
    chk("R10 first five bits MSB first", raw[4:0], e1b[RES_W-1 -: 5]);
    chk("R10 valid after partial read", valid_o, 1);
    run_cycle(1'b0, 2'd0, 1, 2, 1, 1'b0, e2, lat);
    read_result(g);
    chk("R8 overwrite of partly read result", g, e2);
    chk("R10 valid clear after full read", valid_o, 0);
  endtask

  task automatic t_ignore_start();
    longint e, g; int lat;
    run_cycle(1'b1, 2'd1, 1, 6, 0, 1'b1, e, lat);
    chk("R9 mid-cycle start latency", lat, 16 + 2 + 7 + 2 + 1);
    read_result(g);
    chk("R9 result unaffected by mid-cycle inputs", g, e);
    chk("R9 no restart after finish", phase_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst = 1'b0;
    t_cds_basic();
    t_no_cds();
    t_long();
    t_clamp();
    t_extreme();
    t_overwrite();
    t_ignore_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule